// File: doc/BRIEF.md
# Miss-Driven Core Resource Resize Controller

This controller narrows and shrinks parts of an out-of-order core while long data-cache misses are outstanding, when the core cannot use its full machine and the unused parts only burn power. It watches two miss indicators: a flag saying a second-level cache miss is being serviced, and a count of first-level data misses still pending. From these it drives the effective issue width, the effective result-tag broadcast (wakeup) width, and enable masks for the upper halves of the reorder buffer and the register file.

The width resize and the storage resize have separate triggers. The widths are halved only while a second-level miss is pending. The two storage structures are halved when a second-level miss is pending or when enough first-level misses are pending. Sizes are only full or half. A storage upper half is never switched off while it still holds live entries. The controller first raises an allocation hold for that half. It then waits for the structure to report the half empty, and only then drops the enable. When the triggers clear, full size returns one cycle later.

Top module: `miss_resize_ctrl`

## Requirements
- R1: After reset, both widths read 4, both upper-half enables read 1 and both holds read 0.
- R2: One cycle after a cycle with `l2_miss_pend` high, `issue_width` and `wakeup_width` both read 2.
- R3: One cycle after a cycle with `l2_miss_pend` low, both widths read 4, whatever the pending first-level miss count.
- R4: The storage trigger is `l2_miss_pend` high, or `l1d_miss_cnt` of 3 or more. One cycle after a cycle with the trigger active, both storage holds read 1.
- R5: An upper-half enable falls only on the cycle after a cycle in which that structure's `*_upper_empty` input was high while its hold was already asserted. While the half still reports live entries, the enable stays 1.
- R6: Whenever an upper-half enable reads 0, the matching hold reads 1.
- R7: One cycle after a cycle with the storage trigger inactive, the holds read 0 and the enables read 1, even from the half-size state.
- R8: With `l2_miss_pend` low and `l1d_miss_cnt` of 2 or less, the storage outputs stay at full size (hold 0, enable 1).
- R9: The reorder buffer and the register file drain independently. One may reach half size while the other is still draining.
- R10: The width outputs only ever carry the values 4 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| l2_miss_pend | input | 1 | A second-level cache miss is being serviced |
| l1d_miss_cnt | input | CNT_W (4) | Number of pending first-level data misses |
| rob_upper_empty | input | 1 | Reorder buffer upper half holds no valid entries |
| rf_upper_empty | input | 1 | Register file upper partition holds no valid entries |
| issue_width | output | WIDTH_W (3) | Effective issue width, 4 or 2 |
| wakeup_width | output | WIDTH_W (3) | Effective tag broadcast width, 4 or 2 |
| rob_upper_en | output | 1 | Reorder buffer upper half enabled |
| rf_upper_en | output | 1 | Register file upper partition enabled |
| rob_alloc_hold | output | 1 | Block allocation into the reorder buffer upper half |
| rf_alloc_hold | output | 1 | Block allocation into the register file upper partition |

## Verification
The bench builds the block with its defaults: a full width of 4, a 4-bit miss counter and a first-level threshold of 3. With these it can place the count exactly at 2 and 3, the two sides of the storage trigger, and can assert the second-level flag on its own. It can then drive the two empty indications apart, which shows that each structure drains separately. It also checks that the state falls back to full size from both the draining and the half-size states.

// File: rtl/resize_pkg.sv
package resize_pkg;
  typedef enum logic [1:0] {
    ST_FULL  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_HALF  = 2'd2
  } store_state_e;
endpackage

// File: rtl/resize_trigger.sv
module resize_trigger #(
  parameter int CNT_W     = 4,
  parameter int L1_THRESH = 3
) (
  input  logic             l2_miss_pend,
  input  logic [CNT_W-1:0] l1d_miss_cnt,
  output logic             width_trig,
  output logic             store_trig
);
  localparam logic [CNT_W-1:0] THRESH_V = CNT_W'(L1_THRESH);

  always_comb begin
    width_trig = l2_miss_pend;
    store_trig = l2_miss_pend || (l1d_miss_cnt >= THRESH_V);
  end
endmodule

// File: rtl/resize_width_ctrl.sv
module resize_width_ctrl #(
  parameter int FULL_WIDTH = 4,
  parameter int WIDTH_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shrink,
  output logic [WIDTH_W-1:0] issue_width,
  output logic [WIDTH_W-1:0] wakeup_width
);
  localparam logic [WIDTH_W-1:0] W_FULL = WIDTH_W'(FULL_WIDTH);
  localparam logic [WIDTH_W-1:0] W_HALF = WIDTH_W'(FULL_WIDTH / 2);

  logic half_q, half_d;

  always_comb half_d = shrink;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= half_d;
  end

  always_comb begin
    issue_width  = half_q ? W_HALF : W_FULL;
    wakeup_width = half_q ? W_HALF : W_FULL;
  end

  p_width_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shrink |=> (issue_width == W_HALF && wakeup_width == W_HALF));
  p_width_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !shrink |=> (issue_width == W_FULL && wakeup_width == W_FULL));
  p_width_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_width == W_FULL || issue_width == W_HALF));
endmodule

// File: rtl/resize_store_fsm.sv
module resize_store_fsm
  import resize_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic shrink,
  input  logic upper_empty,
  output logic upper_en,
  output logic alloc_hold
);
  store_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_FULL:  if (shrink) st_d = ST_DRAIN;
      ST_DRAIN: if (!shrink) st_d = ST_FULL;
                else if (upper_empty) st_d = ST_HALF;
      ST_HALF:  if (!shrink) st_d = ST_FULL;
      default:  st_d = ST_FULL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_FULL;
    else        st_q <= st_d;
  end

  always_comb begin
    upper_en   = (st_q != ST_HALF);
    alloc_hold = (st_q != ST_FULL);
  end

  p_hold_on_trig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shrink |=> alloc_hold);
  p_off_needs_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upper_en && !(upper_empty && alloc_hold)) |=> upper_en);
  p_off_implies_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !upper_en |-> alloc_hold);
  p_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !shrink |=> (upper_en && !alloc_hold));
endmodule

// File: rtl/miss_resize_ctrl.sv
module miss_resize_ctrl #(
  parameter int FULL_WIDTH = 4,
  parameter int CNT_W      = 4,
  parameter int L1_THRESH  = 3,
  parameter int WIDTH_W    = $clog2(FULL_WIDTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               l2_miss_pend,
  input  logic [CNT_W-1:0]   l1d_miss_cnt,
  input  logic               rob_upper_empty,
  input  logic               rf_upper_empty,
  output logic [WIDTH_W-1:0] issue_width,
  output logic [WIDTH_W-1:0] wakeup_width,
  output logic               rob_upper_en,
  output logic               rf_upper_en,
  output logic               rob_alloc_hold,
  output logic               rf_alloc_hold
);
  localparam int N_STORE = 2;  // index 0: reorder buffer, 1: register file

  logic               width_trig, store_trig;
  logic [N_STORE-1:0] empty_v, en_v, hold_v;

  resize_trigger #(.CNT_W(CNT_W), .L1_THRESH(L1_THRESH)) u_trig (
    .l2_miss_pend (l2_miss_pend),
    .l1d_miss_cnt (l1d_miss_cnt),
    .width_trig   (width_trig),
    .store_trig   (store_trig)
  );

  resize_width_ctrl #(.FULL_WIDTH(FULL_WIDTH), .WIDTH_W(WIDTH_W)) u_width (
    .clk          (clk),
    .rst_n        (rst_n),
    .shrink       (width_trig),
    .issue_width  (issue_width),
    .wakeup_width (wakeup_width)
  );

  assign empty_v = {rf_upper_empty, rob_upper_empty};

  for (genvar g = 0; g < N_STORE; g++) begin : g_store
    resize_store_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .shrink      (store_trig),
      .upper_empty (empty_v[g]),
      .upper_en    (en_v[g]),
      .alloc_hold  (hold_v[g])
    );
  end

  assign rob_upper_en   = en_v[0];
  assign rf_upper_en    = en_v[1];
  assign rob_alloc_hold = hold_v[0];
  assign rf_alloc_hold  = hold_v[1];

  p_quiet_no_resize_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!l2_miss_pend && l1d_miss_cnt < CNT_W'(L1_THRESH)) |=>
      (rob_upper_en && rf_upper_en && !rob_alloc_hold && !rf_alloc_hold));
endmodule

// File: tb/miss_resize_ctrl_test.sv
module miss_resize_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       l2_miss_pend;
  logic [3:0] l1d_miss_cnt;
  logic       rob_upper_empty, rf_upper_empty;
  logic [2:0] issue_width, wakeup_width;
  logic       rob_upper_en, rf_upper_en, rob_alloc_hold, rf_alloc_hold;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  miss_resize_ctrl uut (
    .clk(clk), .rst_n(rst_n), .l2_miss_pend(l2_miss_pend),
    .l1d_miss_cnt(l1d_miss_cnt), .rob_upper_empty(rob_upper_empty),
    .rf_upper_empty(rf_upper_empty), .issue_width(issue_width),
    .wakeup_width(wakeup_width), .rob_upper_en(rob_upper_en),
    .rf_upper_en(rf_upper_en), .rob_alloc_hold(rob_alloc_hold),
    .rf_alloc_hold(rf_alloc_hold)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at a falling edge, then wait one rising edge, sample at next falling edge
  task automatic step(input logic l2, input int cnt, input logic re, input logic fe);
    l2_miss_pend = l2; l1d_miss_cnt = 4'(cnt);
    rob_upper_empty = re; rf_upper_empty = fe;
    @(negedge clk);
  endtask

  task automatic chk_store(input string req, input int ren, input int rh,
                           input int fen, input int fh);
    chk({req, " rob_en"}, rob_upper_en, ren);
    chk({req, " rob_hold"}, rob_alloc_hold, rh);
    chk({req, " rf_en"}, rf_upper_en, fen);
    chk({req, " rf_hold"}, rf_alloc_hold, fh);
  endtask

  task automatic t_reset_r1;
    chk("R1 issue", issue_width, 4);
    chk("R1 wakeup", wakeup_width, 4);
    chk_store("R1", 1, 0, 1, 0);
  endtask

  task automatic t_l2_r2;
    step(1'b1, 0, 1'b0, 1'b0);
    chk("R2 issue", issue_width, 2);
    chk("R2 wakeup", wakeup_width, 2);
    chk_store("R4 l2", 1, 1, 1, 1);
    step(1'b0, 0, 1'b0, 1'b0);
    chk("R3 issue", issue_width, 4);
    chk("R10 wakeup", wakeup_width, 4);
    chk_store("R7 from drain", 1, 0, 1, 0);
  endtask

  task automatic t_l1_thresh_r4;
    step(1'b0, 2, 1'b1, 1'b1);
    chk_store("R8 cnt2", 1, 0, 1, 0);
    step(1'b0, 3, 1'b1, 1'b1);
    chk("R3 l1 only", issue_width, 4);
    chk_store("R4 cnt3", 1, 1, 1, 1);
    step(1'b0, 3, 1'b1, 1'b1);
    chk_store("R5 both empty", 0, 1, 0, 1);
    chk("R6 rob", (!rob_upper_en) ? int'(rob_alloc_hold) : 1, 1);
    step(1'b0, 1, 1'b1, 1'b1);
    chk_store("R7 from half", 1, 0, 1, 0);
  endtask

  task automatic t_separate_r9;
    step(1'b1, 5, 1'b0, 1'b0);
    chk_store("R4 l2+cnt", 1, 1, 1, 1);
    step(1'b1, 5, 1'b0, 1'b0);
    chk_store("R5 not empty", 1, 1, 1, 1);
    step(1'b1, 5, 1'b1, 1'b0);
    chk_store("R9 rob first", 0, 1, 1, 1);
    step(1'b1, 5, 1'b1, 1'b1);
    chk_store("R9 rf follows", 0, 1, 0, 1);
    chk("R2 still", issue_width, 2);
    step(1'b0, 0, 1'b1, 1'b1);
    chk_store("R7 release", 1, 0, 1, 0);
    chk("R3 release", issue_width, 4);
  endtask

  initial begin
    rst_n = 1'b0; l2_miss_pend = 1'b0; l1d_miss_cnt = '0;
    rob_upper_empty = 1'b0; rf_upper_empty = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_l2_r2();
    t_l1_thresh_r4();
    t_separate_r9();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule